// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit

This block is a purely combinational 32-bit arithmetic-logic unit for the integer datapath of a small processor core. It takes two operands and a 4-bit operation select, and drives one result. The operations are wrapping add and subtract, three bitwise operations, two set-less-than comparisons and three shifts. One comparison reads the operands as two's-complement numbers and the other reads them as unsigned numbers.

The block has no clock, no reset and no storage. Its result follows its inputs within the same cycle, so the execute stage that instantiates it registers the result downstream. For shifts, only the low five bits of the second operand give the shift amount. Arithmetic overflow wraps silently and produces no flag. Select codes that are not assigned to an operation produce zero.

Top module: `int_alu`

## Requirements
- R1: Select code 0 (add) drives `(op_a + op_b) mod 2^32`; a carry out of bit 31 is dropped and nothing signals it.
- R2: Select code 1 (subtract) drives `(op_a - op_b) mod 2^32`; a borrow wraps silently.
- R3: Select codes 2, 3 and 4 drive the bitwise AND, OR and XOR of the operands.
- R4: Select code 5 (signed less-than) drives 32'd1 when op_a < op_b as two's-complement values, else 32'd0.
- R5: Select code 6 (unsigned less-than) drives 32'd1 when op_a < op_b as unsigned values, else 32'd0.
- R6: Select code 7 shifts op_a left by op_b[4:0] and fills with zeros.
- R7: Select code 8 shifts op_a right by op_b[4:0] and fills with zeros.
- R8: Select code 9 shifts op_a right by op_b[4:0] and fills with copies of op_a[31].
- R9: For codes 7, 8 and 9, op_b[31:5] has no effect; amounts of 32 or more act as their value modulo 32.
- R10: Select codes 10 to 15 drive a result of zero.
- R11: The result is a function of the present inputs alone and is due in the same cycle that the inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand; the value that is shifted |
| op_b | input | 32 | Second operand; bits [4:0] give the shift amount |
| op_sel | input | 4 | Operation select code |
| result | output | 32 | Operation result |

## Verification
Every result is due zero cycles after its stimulus. The bench drives the operands and the select code just after a rising edge of its own pacing clock and samples the result at the next falling edge, half a period later. Because of this, no check ever reads a value from an earlier operation. The sweep revisits each operand pair under every select code, including the unused codes, so a result cannot depend on an earlier input.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   localparam int unsigned DATA_W   = 32;
   localparam int unsigned OPSEL_W  = 4;

   typedef enum logic [OPSEL_W-1:0] {
      OPC_ADD  = 4'd0,
      OPC_SUB  = 4'd1,
      OPC_AND  = 4'd2,
      OPC_OR   = 4'd3,
      OPC_XOR  = 4'd4,
      OPC_SLT  = 4'd5,
      OPC_SLTU = 4'd6,
      OPC_SLL  = 4'd7,
      OPC_SRL  = 4'd8,
      OPC_SRA  = 4'd9
   } alu_opc_e;

endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] lhs,
   input  logic [WIDTH-1:0] rhs,
   input  logic             subtract,
   output logic [WIDTH-1:0] total
);
   logic [WIDTH-1:0] rhs_eff;

   always_comb begin
      rhs_eff = subtract ? ~rhs : rhs;
      total   = lhs + rhs_eff + {{(WIDTH-1){1'b0}}, subtract};
   end
endmodule

// File: rtl/int_alu_compare.sv
module int_alu_compare #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] lhs,
   input  logic [WIDTH-1:0] rhs,
   output logic             lt_signed,
   output logic             lt_unsigned
);
   localparam int unsigned MSB = WIDTH - 1;

   logic sign_differs;

   always_comb begin
      lt_unsigned  = (lhs < rhs);
      sign_differs = lhs[MSB] ^ rhs[MSB];
      lt_signed    = sign_differs ? lhs[MSB] : lt_unsigned;
   end
endmodule

// File: rtl/int_alu_shifter.sv
module int_alu_shifter #(
   parameter int unsigned WIDTH  = 32,
   parameter bit          BARREL = 1'b1,
   localparam int unsigned AMT_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] value,
   input  logic [AMT_W-1:0] amount,
   input  logic             go_left,
   input  logic             sign_fill,
   output logic [WIDTH-1:0] shifted
);
   logic fill_bit;
   assign fill_bit = sign_fill & value[WIDTH-1] & ~go_left;

   if (BARREL) begin : g_barrel
      logic [WIDTH-1:0] stage [AMT_W+1];
      logic [WIDTH-1:0] flipped_in;
      logic [WIDTH-1:0] flipped_out;

      for (genvar i = 0; i < WIDTH; i++) begin : g_rev_in
         assign flipped_in[i] = value[WIDTH-1-i];
      end

      assign stage[0] = go_left ? flipped_in : value;

      for (genvar s = 0; s < AMT_W; s++) begin : g_stage
         localparam int unsigned STEP = 1 << s;
         assign stage[s+1] = amount[s]
            ? {{STEP{fill_bit}}, stage[s][WIDTH-1:STEP]}
            : stage[s];
      end

      for (genvar i = 0; i < WIDTH; i++) begin : g_rev_out
         assign flipped_out[i] = stage[AMT_W][WIDTH-1-i];
      end

      assign shifted = go_left ? flipped_out : stage[AMT_W];
   end else begin : g_operator
      logic [2*WIDTH-1:0] wide;
      logic [2*WIDTH-1:0] wide_shr;
      always_comb begin
         wide     = {{WIDTH{fill_bit}}, value};
         wide_shr = wide >> amount;
         shifted  = go_left ? (value << amount) : wide_shr[WIDTH-1:0];
      end
   end
endmodule

// File: rtl/int_alu.sv
module int_alu #(
   parameter int unsigned XLEN        = int_alu_pkg::DATA_W,
   parameter int unsigned SEL_W       = int_alu_pkg::OPSEL_W,
   parameter bit          BARREL_SHIFT = 1'b1
) (
   input  logic [XLEN-1:0]  op_a,
   input  logic [XLEN-1:0]  op_b,
   input  logic [SEL_W-1:0] op_sel,
   output logic [XLEN-1:0]  result
);
   import int_alu_pkg::*;

   localparam int unsigned SHAMT_W = $clog2(XLEN);

   if (XLEN < 8 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
      $error("int_alu: XLEN must be a power of two of at least 8");
   end
   if (SEL_W != OPSEL_W) begin : g_bad_sel
      $error("int_alu: SEL_W must match the package select width");
   end

   logic [XLEN-1:0] arith_out;
   logic [XLEN-1:0] shift_out;
   logic            lt_s;
   logic            lt_u;
   logic            is_sub;
   logic            is_left;
   logic            is_arith;

   assign is_sub   = (op_sel == OPC_SUB);
   assign is_left  = (op_sel == OPC_SLL);
   assign is_arith = (op_sel == OPC_SRA);

   int_alu_addsub #(.WIDTH(XLEN)) u_addsub (
      .lhs      (op_a),
      .rhs      (op_b),
      .subtract (is_sub),
      .total    (arith_out)
   );

   int_alu_compare #(.WIDTH(XLEN)) u_compare (
      .lhs         (op_a),
      .rhs         (op_b),
      .lt_signed   (lt_s),
      .lt_unsigned (lt_u)
   );

   int_alu_shifter #(.WIDTH(XLEN), .BARREL(BARREL_SHIFT)) u_shifter (
      .value     (op_a),
      .amount    (op_b[SHAMT_W-1:0]),
      .go_left   (is_left),
      .sign_fill (is_arith),
      .shifted   (shift_out)
   );

   always_comb begin
      result = '0;
      case (op_sel)
         OPC_ADD,
         OPC_SUB:  result = arith_out;
         OPC_AND:  result = op_a & op_b;
         OPC_OR:   result = op_a | op_b;
         OPC_XOR:  result = op_a ^ op_b;
         OPC_SLT:  result = {{(XLEN-1){1'b0}}, lt_s};
         OPC_SLTU: result = {{(XLEN-1){1'b0}}, lt_u};
         OPC_SLL,
         OPC_SRL,
         OPC_SRA:  result = shift_out;
         default:  result = '0;
      endcase
   end
endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker #(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned SEL_W = 4
) (
   input logic [XLEN-1:0]  op_a,
   input logic [XLEN-1:0]  op_b,
   input logic [SEL_W-1:0] op_sel,
   input logic [XLEN-1:0]  result
);
   localparam int unsigned SHW = $clog2(XLEN);

   always_comb begin
      if (!$isunknown({op_a, op_b, op_sel, result})) begin
         // R1
         if (op_sel == 4'd0)
            a_r1_add_wraps: assert (result - op_b == op_a);
         // R2
         if (op_sel == 4'd1)
            a_r2_sub_wraps: assert (result + op_b == op_a);
         // R4
         if (op_sel == 4'd5)
            a_r4_slt_bool: assert (result[XLEN-1:1] == '0
               && result[0] == ($signed(op_a) < $signed(op_b)));
         // R5
         if (op_sel == 4'd6)
            a_r5_sltu_bool: assert (result[XLEN-1:1] == '0
               && result[0] == (op_a < op_b));
         // R8
         if (op_sel == 4'd9 && op_a[XLEN-1])
            a_r8_sign_kept: assert (result[XLEN-1]);
         // R7
         if (op_sel == 4'd8 && op_b[SHW-1:0] != '0)
            a_r7_zero_fill: assert (!result[XLEN-1]);
         // R9
         if (op_sel == 4'd7)
            a_r9_low_amount: assert (result == (op_a << op_b[SHW-1:0]));
         // R10
         if (op_sel > 4'd9)
            a_r10_unused_zero: assert (result == '0);
      end
   end
endmodule

bind int_alu int_alu_checker #(.XLEN(XLEN), .SEL_W(SEL_W)) u_int_alu_checker (
   .op_a   (op_a),
   .op_b   (op_b),
   .op_sel (op_sel),
   .result (result)
);

// File: tb/test_int_alu.sv
module test_int_alu;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;
   localparam int NVALS      = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [3:0]  op_sel = '0;
   logic [31:0] result;

   int checks   = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   int_alu i_int_alu (
      .op_a   (op_a),
      .op_b   (op_b),
      .op_sel (op_sel),
      .result (result)
   );

   function automatic logic [31:0] pick(input int idx);
      case (idx)
         0:  pick = 32'h0000_0000;
         1:  pick = 32'h0000_0001;
         2:  pick = 32'hFFFF_FFFF;
         3:  pick = 32'h8000_0000;
         4:  pick = 32'h7FFF_FFFF;
         5:  pick = 32'h1234_5678;
         6:  pick = 32'hA5A5_A5A5;
         7:  pick = 32'h0000_001F;
         8:  pick = 32'h0000_0020;
         9:  pick = 32'h0000_0021;
         10: pick = 32'hFFFF_FFE3;
         default: pick = 32'h0000_003F;
      endcase
   endfunction

   function automatic string tag(input logic [3:0] sel);
      case (sel)
         4'd0: tag = "R1 add";
         4'd1: tag = "R2 sub";
         4'd2, 4'd3, 4'd4: tag = "R3 bitwise";
         4'd5: tag = "R4 slt";
         4'd6: tag = "R5 sltu";
         4'd7: tag = "R6/R9 sll";
         4'd8: tag = "R7/R9 srl";
         4'd9: tag = "R8/R9 sra";
         default: tag = "R10 unused";
      endcase
   endfunction

   function automatic logic [31:0] model(input logic [3:0] sel,
                                         input logic [31:0] a,
                                         input logic [31:0] b);
      longint unsigned wa, wb;
      int amt;
      logic [31:0] r;
      wa  = {32'b0, a};
      wb  = {32'b0, b};
      amt = int'(b % 32);
      r   = '0;
      case (sel)
         4'd0: r = 32'((wa + wb) % 64'h1_0000_0000);
         4'd1: r = 32'((wa + 64'h1_0000_0000 - wb) % 64'h1_0000_0000);
         4'd2: r = a & b;
         4'd3: r = a | b;
         4'd4: r = a ^ b;
         4'd5: begin
            longint sa, sb;
            sa = a[31] ? longint'(wa) - 64'sh1_0000_0000 : longint'(wa);
            sb = b[31] ? longint'(wb) - 64'sh1_0000_0000 : longint'(wb);
            r = (sa < sb) ? 32'd1 : 32'd0;
         end
         4'd6: r = (wa < wb) ? 32'd1 : 32'd0;
         4'd7: r = 32'((wa * (64'd1 << amt)) % 64'h1_0000_0000);
         4'd8: r = 32'(wa / (64'd1 << amt));
         4'd9: begin
            r = 32'(wa / (64'd1 << amt));
            if (a[31])
               for (int k = 0; k < amt; k++) r[31-k] = 1'b1;
         end
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic apply_check(input logic [3:0] sel, input logic [31:0] a,
                              input logic [31:0] b, input string extra);
      logic [31:0] exp;
      @(posedge clk);
      #1;
      op_sel = sel;
      op_a   = a;
      op_b   = b;
      exp    = model(sel, a, b);
      @(negedge clk);
      checks++;
      if (result !== exp) begin
         failures++;
         $display("FAIL %s%s sel=%0d a=%h b=%h actual=%h expected=%h",
                  tag(sel), extra, sel, a, b, result, exp);
      end
   endtask

   initial begin
      int cyc = 0;
      while (!finished) begin
         @(posedge clk);
         cyc++;
         if (cyc > WATCHDOG && !finished) begin
            failures++;
            finished = 1'b1;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Reset/idle state: all-zero inputs give zero (R1)
      @(negedge clk);
      checks++;
      if (result !== 32'd0) begin
         failures++;
         $display("FAIL R1 idle actual=%h expected=%h", result, 32'd0);
      end

      // Named corner cases
      apply_check(4'd0, 32'hFFFF_FFFF, 32'h1, " carry dropped");        // R1
      apply_check(4'd0, 32'h7FFF_FFFF, 32'h1, " signed overflow");      // R1
      apply_check(4'd1, 32'h8000_0000, 32'h1, " signed underflow");     // R2
      apply_check(4'd1, 32'h0, 32'h1, " borrow wraps");                 // R2
      apply_check(4'd5, 32'hFFFF_FFFF, 32'h1, " -1<1 signed");          // R4
      apply_check(4'd6, 32'hFFFF_FFFF, 32'h1, " -1<1 unsigned");        // R5
      apply_check(4'd5, 32'h8000_0000, 32'h7FFF_FFFF, " min<max");      // R4
      apply_check(4'd6, 32'h8000_0000, 32'h7FFF_FFFF, " min<max u");    // R5
      apply_check(4'd9, 32'h8000_0000, 32'd31, " sra by 31");           // R8
      apply_check(4'd8, 32'h8000_0000, 32'd31, " srl by 31");           // R7
      apply_check(4'd7, 32'h0000_0001, 32'd31, " sll by 31");           // R6
      apply_check(4'd7, 32'h1234_5678, 32'd32, " sll by 32");           // R9
      apply_check(4'd9, 32'hF000_0000, 32'hFFFF_FFE4, " sra big b");    // R9
      apply_check(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, " code 15");     // R10

      // Sweep of every code over all operand pairs (R1..R11)
      for (int s = 0; s < 16; s++)
         for (int i = 0; i < NVALS; i++)
            for (int j = 0; j < NVALS; j++)
               apply_check(4'(s), pick(i), pick(j), "");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule